// File: doc/BRIEF.md
# Branch Target and Condition Resolver

This block works out where execution continues after a control-transfer instruction in a 16-bit segmented processor. The decoder hands it a branch kind, a condition code, the displacement or address operands, the flag bits, the count register and the address of the instruction that follows. Any operand that comes from memory has already been read. One cycle later the block returns the new instruction pointer, the new code segment, a taken indication and the count register value to write back.

The block covers three groups of transfers. The first is relative jumps with a short or near displacement. The second is far jumps with an immediate target and jumps through a near or far indirect value. The third is conditional jumps over sixteen flag conditions, three counted-loop forms and a jump taken when the count is zero. The conditional, loop and count-zero forms all use the short displacement. The block never changes a flag.

Top module: `branch_resolver`

## Requirements
- R1: Kind code 0 (short) always branches, to nextIp plus the low 8 bits of dispIn sign-extended to 16 bits, with 16-bit wraparound.
- R2: Kind code 1 (near) always branches, to nextIp plus all 16 bits of dispIn, modulo 2^16. CS is unchanged.
- R3: Kind code 2 (far immediate) loads IP from farIn[15:0] and CS from farIn[31:16].
- R4: Kind code 3 (near indirect) loads IP from indIn[15:0] and keeps CS. Kind code 4 (far indirect) loads IP from indIn[15:0] and CS from indIn[31:16].
- R5: Kind code 5 (conditional) uses condIn. flagsIn bits are [0]=carry, [1]=zero, [2]=sign, [3]=overflow, [4]=parity. The unsigned codes are: 2 below (C=1), 3 above-or-equal (C=0), 6 below-or-equal (C or Z), 7 above (C=0 and Z=0).
- R6: The signed codes are: 12 less (S≠O), 13 greater-or-equal (S=O), 14 less-or-equal (S≠O or Z=1), 15 greater (S=O and Z=0).
- R7: The single-flag codes are: 0 overflow, 1 no overflow, 4 zero, 5 not zero, 8 sign, 9 no sign, 10 parity, 11 no parity. An odd code is always the inverse of the even code below it. A taken conditional branch targets the short relative address of R1.
- R8: Kind code 6 (counted loop) writes back count-1, modulo 2^16. It branches to the short target when that result is nonzero, so a starting count of 0 branches and leaves 0xFFFF.
- R9: Kind code 7 (loop while zero) and kind code 8 (loop while not zero) always write back count-1. They branch only if that result is nonzero and Z is 1 (code 7) or Z is 0 (code 8).
- R10: Kind code 9 branches to the short target when countIn is 0. It, and every kind other than 6, 7 and 8, returns countIn unchanged.
- R11: When no branch is taken (including for kind codes 10 to 15), newIp equals nextIp, newCs equals curCs and taken is low.
- R12: outValid is high exactly one cycle after a cycle with inValid high, and results are updated only then. All outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe, one cycle |
| kindIn | input | 4 | Branch kind code |
| condIn | input | 4 | Condition code for kind 5 |
| flagsIn | input | 5 | Parity, overflow, sign, zero, carry (bit 4 down to 0) |
| dispIn | input | 16 | Relative displacement (short uses low 8 bits) |
| farIn | input | 32 | Far immediate, segment:offset |
| indIn | input | 32 | Indirect value already read, segment:offset |
| countIn | input | 16 | Count register |
| nextIp | input | 16 | Address of following instruction |
| curCs | input | 16 | Current code segment |
| outValid | output | 1 | Result valid |
| taken | output | 1 | Branch taken |
| newIp | output | 16 | Resulting instruction pointer |
| newCs | output | 16 | Resulting code segment |
| countOut | output | 16 | Count register to write back |

## Verification
The bench uses the default 16-bit address width and the 8-bit short displacement. At that width it can sweep every condition code against all 32 flag combinations and every short displacement near the top of the segment, where wraparound occurs. The count is 16 bits wide, so the bench drives the loop forms at the wrap points 0, 1, 2, 0x8000 and 0xFFFF under both values of the zero flag, rather than trying every count value.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  typedef enum logic [3:0] {
    K_SHORT    = 4'd0,
    K_NEAR     = 4'd1,
    K_FAR      = 4'd2,
    K_IND_NEAR = 4'd3,
    K_IND_FAR  = 4'd4,
    K_COND     = 4'd5,
    K_LOOP     = 4'd6,
    K_LOOP_EQ  = 4'd7,
    K_LOOP_NE  = 4'd8,
    K_CNT_ZERO = 4'd9
  } brKind_e;

  typedef enum logic [2:0] {
    T_NEXT, T_REL_SHORT, T_REL_NEAR, T_FAR_IMM, T_IND_NEAR, T_IND_FAR
  } tgtSel_e;

  typedef struct packed {
    tgtSel_e sel;
    logic    take;
    logic    decCount;
  } ctlStrobe_t;
endpackage

// File: rtl/bcr_control.sv
module bcr_control
  import bcr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [3:0]       kindIn,
  input  logic [3:0]       condIn,
  input  logic [4:0]       flagsIn,
  input  logic [CNT_W-1:0] countIn,
  output ctlStrobe_t       ctl
);
  logic cf, zf, sf, ovf, pf;
  logic baseCond, condMet, cntWillBeNz, cntIsZero;

  assign cf  = flagsIn[0];
  assign zf  = flagsIn[1];
  assign sf  = flagsIn[2];
  assign ovf = flagsIn[3];
  assign pf  = flagsIn[4];

  always_comb begin
    unique case (condIn[3:1])
      3'd0: baseCond = ovf;
      3'd1: baseCond = cf;
      3'd2: baseCond = zf;
      3'd3: baseCond = cf | zf;
      3'd4: baseCond = sf;
      3'd5: baseCond = pf;
      3'd6: baseCond = sf ^ ovf;
      default: baseCond = (sf ^ ovf) | zf;
    endcase
  end
  assign condMet     = baseCond ^ condIn[0];
  assign cntWillBeNz = (countIn != CNT_W'(1));
  assign cntIsZero   = (countIn == '0);

  function automatic ctlStrobe_t mk(input logic go, input tgtSel_e s, input logic dec);
    ctlStrobe_t c;
    c.take     = go;
    c.sel      = go ? s : T_NEXT;
    c.decCount = dec;
    return c;
  endfunction

  always_comb begin
    case (brKind_e'(kindIn))
      K_SHORT:    ctl = mk(1'b1, T_REL_SHORT, 1'b0);
      K_NEAR:     ctl = mk(1'b1, T_REL_NEAR, 1'b0);
      K_FAR:      ctl = mk(1'b1, T_FAR_IMM, 1'b0);
      K_IND_NEAR: ctl = mk(1'b1, T_IND_NEAR, 1'b0);
      K_IND_FAR:  ctl = mk(1'b1, T_IND_FAR, 1'b0);
      K_COND:     ctl = mk(condMet, T_REL_SHORT, 1'b0);
      K_LOOP:     ctl = mk(cntWillBeNz, T_REL_SHORT, 1'b1);
      K_LOOP_EQ:  ctl = mk(cntWillBeNz & zf, T_REL_SHORT, 1'b1);
      K_LOOP_NE:  ctl = mk(cntWillBeNz & ~zf, T_REL_SHORT, 1'b1);
      K_CNT_ZERO: ctl = mk(cntIsZero, T_REL_SHORT, 1'b0);
      default:    ctl = mk(1'b0, T_NEXT, 1'b0);
    endcase
  end

  // R10: count-zero test never requests a count write
  p_cntzero_keeps_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && kindIn == K_CNT_ZERO) |-> !ctl.decCount);
  // R9: the conditional loop forms decrement even when falling through
  p_loopcc_dec_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (kindIn == K_LOOP_EQ || kindIn == K_LOOP_NE)) |-> ctl.decCount);
  // R11: a strobe without take must select the fall-through address
  p_nottaken_next_r11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !ctl.take) |-> (ctl.sel == T_NEXT));
endmodule

// File: rtl/bcr_datapath.sv
module bcr_datapath
  import bcr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  ctlStrobe_t          ctl,
  input  logic [ADDR_W-1:0]   dispIn,
  input  logic [2*ADDR_W-1:0] farIn,
  input  logic [2*ADDR_W-1:0] indIn,
  input  logic [ADDR_W-1:0]   countIn,
  input  logic [ADDR_W-1:0]   nextIp,
  input  logic [ADDR_W-1:0]   curCs,
  output logic                outValid,
  output logic                taken,
  output logic [ADDR_W-1:0]   newIp,
  output logic [ADDR_W-1:0]   newCs,
  output logic [ADDR_W-1:0]   countOut
);
  localparam int EXT_W = ADDR_W - SHORT_W;

  logic [ADDR_W-1:0] shortExt, ipCalc, csCalc, cntCalc;

  assign shortExt = {{EXT_W{dispIn[SHORT_W-1]}}, dispIn[SHORT_W-1:0]};

  always_comb begin
    ipCalc = nextIp;
    csCalc = curCs;
    case (ctl.sel)
      T_REL_SHORT: ipCalc = nextIp + shortExt;
      T_REL_NEAR:  ipCalc = nextIp + dispIn;
      T_FAR_IMM:   begin ipCalc = farIn[ADDR_W-1:0]; csCalc = farIn[2*ADDR_W-1:ADDR_W]; end
      T_IND_NEAR:  ipCalc = indIn[ADDR_W-1:0];
      T_IND_FAR:   begin ipCalc = indIn[ADDR_W-1:0]; csCalc = indIn[2*ADDR_W-1:ADDR_W]; end
      default:     ;
    endcase
    cntCalc = ctl.decCount ? countIn - ADDR_W'(1) : countIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      taken    <= 1'b0;
      newIp    <= '0;
      newCs    <= '0;
      countOut <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        taken    <= ctl.take;
        newIp    <= ipCalc;
        newCs    <= csCalc;
        countOut <= cntCalc;
      end
    end
  end

  // R12: one-cycle latency
  p_latency_r12: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_no_spurious_r12: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(newIp) && $stable(countOut)));
  // R11: fall-through keeps segment and returns next address
  p_fallthrough_r11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !ctl.take) |=> (!taken && newIp == $past(nextIp) && newCs == $past(curCs)));
  // R8: decrement request yields count minus one
  p_count_dec_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ctl.decCount) |=> (countOut == $past(countIn) - ADDR_W'(1)));
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import bcr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [3:0]          kindIn,
  input  logic [3:0]          condIn,
  input  logic [4:0]          flagsIn,
  input  logic [ADDR_W-1:0]   dispIn,
  input  logic [2*ADDR_W-1:0] farIn,
  input  logic [2*ADDR_W-1:0] indIn,
  input  logic [ADDR_W-1:0]   countIn,
  input  logic [ADDR_W-1:0]   nextIp,
  input  logic [ADDR_W-1:0]   curCs,
  output logic                outValid,
  output logic                taken,
  output logic [ADDR_W-1:0]   newIp,
  output logic [ADDR_W-1:0]   newCs,
  output logic [ADDR_W-1:0]   countOut
);
  ctlStrobe_t ctl;

  bcr_control #(.CNT_W(ADDR_W)) u_control (
    .clk(clk), .rstN(rstN), .inValid(inValid), .kindIn(kindIn),
    .condIn(condIn), .flagsIn(flagsIn), .countIn(countIn), .ctl(ctl)
  );

  bcr_datapath #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ctl(ctl),
    .dispIn(dispIn), .farIn(farIn), .indIn(indIn), .countIn(countIn),
    .nextIp(nextIp), .curCs(curCs), .outValid(outValid), .taken(taken),
    .newIp(newIp), .newCs(newCs), .countOut(countOut)
  );
endmodule

// File: tb/branch_resolver_bench.sv
module branch_resolver_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [3:0] kindIn = '0, condIn = '0;
  logic [4:0] flagsIn = '0;
  logic [15:0] dispIn = '0, countIn = '0, nextIp = '0, curCs = '0;
  logic [31:0] farIn = '0, indIn = '0;
  logic outValid, taken;
  logic [15:0] newIp, newCs, countOut;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  branch_resolver u_branch_resolver (
    .clk(clk), .rstN(rstN), .inValid(inValid), .kindIn(kindIn), .condIn(condIn),
    .flagsIn(flagsIn), .dispIn(dispIn), .farIn(farIn), .indIn(indIn),
    .countIn(countIn), .nextIp(nextIp), .curCs(curCs), .outValid(outValid),
    .taken(taken), .newIp(newIp), .newCs(newCs), .countOut(countOut)
  );

  task automatic cmp(input string req, input logic [49:0] act, input logic [49:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fire(input string req, input logic eTaken, input logic [15:0] eIp,
                      input logic [15:0] eCs, input logic [15:0] eCnt);
    @(negedge clk) inValid = 1'b1;
    @(negedge clk) inValid = 1'b0;
    cmp(req, {outValid, taken, eIp === eIp ? newIp : newIp, newCs, countOut},
             {1'b1, eTaken, eIp, eCs, eCnt});
  endtask

  function automatic logic condRef(input int code, input logic [4:0] f);
    logic c, z, s, o, p;
    {p, o, s, z, c} = f;
    case (code)
      0: return o;            1: return !o;
      2: return c;            3: return !c;
      4: return z;            5: return !z;
      6: return c || z;       7: return !c && !z;
      8: return s;            9: return !s;
      10: return p;           11: return !p;
      12: return s != o;      13: return s == o;
      14: return (s != o) || z;
      default: return (s == o) && !z;
    endcase
  endfunction

  function automatic logic [15:0] shortTgt(input logic [15:0] nip, input logic [15:0] d);
    int sd;
    sd = (d[7:0] >= 128) ? int'(d[7:0]) - 256 : int'(d[7:0]);
    return 16'((int'(nip) + sd) & 16'hFFFF);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    cmp("R12 reset", {outValid, taken, newIp, newCs, countOut}, '0);
    rstN = 1'b1;
    curCs = 16'hA000; countIn = 16'h0042;

    // R1: every short displacement, near segment top (wrap) and bottom
    kindIn = 4'd0;
    for (int d = 0; d < 256; d++) begin
      dispIn = 16'(d) | 16'h5500; nextIp = 16'hFFC0;
      fire("R1 short", 1'b1, shortTgt(nextIp, dispIn), 16'hA000, 16'h0042);
    end
    nextIp = 16'h0010; dispIn = 16'h0080;
    fire("R1 short back", 1'b1, 16'hFF90, 16'hA000, 16'h0042);

    // R2: near relative with wrap
    kindIn = 4'd1; nextIp = 16'hF000; dispIn = 16'h2345;
    fire("R2 near wrap", 1'b1, 16'h1345, 16'hA000, 16'h0042);
    nextIp = 16'h1000; dispIn = 16'h8000;
    fire("R2 near", 1'b1, 16'h9000, 16'hA000, 16'h0042);

    // R3, R4: far and indirect
    kindIn = 4'd2; farIn = 32'hBEEF_1234;
    fire("R3 far imm", 1'b1, 16'h1234, 16'hBEEF, 16'h0042);
    kindIn = 4'd3; indIn = 32'hCAFE_5678;
    fire("R4 near ind", 1'b1, 16'h5678, 16'hA000, 16'h0042);
    kindIn = 4'd4;
    fire("R4 far ind", 1'b1, 16'h5678, 16'hCAFE, 16'h0042);

    // R5 R6 R7 R11: every condition against every flag pattern
    kindIn = 4'd5; nextIp = 16'h2000; dispIn = 16'h00F0;
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 32; f++) begin
        logic t;
        condIn = 4'(c); flagsIn = 5'(f);
        t = condRef(c, 5'(f));
        fire(c >= 12 ? "R6 signed" : ((c == 2 || c == 3 || c == 6 || c == 7) ? "R5 unsigned" :
             (t ? "R7 flag" : "R11 fallthrough")),
             t, t ? 16'h1FF0 : 16'h2000, 16'hA000, 16'h0042);
      end
    end

    // R8 R9: loop forms at count wrap points
    nextIp = 16'h3000; dispIn = 16'h00FE;
    for (int k = 6; k <= 8; k++) begin
      for (int z = 0; z < 2; z++) begin
        for (int i = 0; i < 5; i++) begin
          logic [15:0] c0, c1;
          logic t;
          c0 = (i == 0) ? 16'h0000 : (i == 1) ? 16'h0001 : (i == 2) ? 16'h0002 :
               (i == 3) ? 16'h8000 : 16'hFFFF;
          c1 = c0 - 16'd1;
          t = (c1 != 0) && (k == 6 || (k == 7 && z == 1) || (k == 8 && z == 0));
          kindIn = 4'(k); flagsIn = z ? 5'b00010 : 5'b11101; countIn = c0;
          fire(k == 6 ? "R8 loop" : "R9 loopcc", t, t ? 16'h2FFE : 16'h3000, 16'hA000, c1);
        end
      end
    end

    // R10: count-zero jump, count untouched
    kindIn = 4'd9; countIn = 16'h0000;
    fire("R10 cnt zero", 1'b1, 16'h2FFE, 16'hA000, 16'h0000);
    countIn = 16'h0001;
    fire("R10 cnt nz", 1'b0, 16'h3000, 16'hA000, 16'h0001);

    // R11: undefined kinds fall through
    kindIn = 4'd12; countIn = 16'h0007;
    fire("R11 undefined kind", 1'b0, 16'h3000, 16'hA000, 16'h0007);

    // R12: no strobe, no valid, results held
    @(negedge clk);
    cmp("R12 idle", {outValid, taken, newIp, newCs, countOut},
        {1'b0, 1'b0, 16'h3000, 16'hA000, 16'h0007});

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule